// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block presents interrupts to one processor. It keeps a 32-bit pending word made of the current processor priority (top byte) and a 24-bit source number (low bits), together with the priority of the interrupt now pending and an inter-processor interrupt (IPI) request priority. Lower priority values are more favoured throughout. A source controller offers interrupts one cycle at a time. Each offer is either taken or refused in the same cycle. A taken offer may displace a pending interrupt, and the displaced source then gets a reject notice so it can try again later.

The processor works through a single-cycle register port. It can accept the pending interrupt, poll without side effects, change its priority, change the IPI priority, or signal end-of-interrupt. Lowering the IPI priority below the processor priority can inject the fixed IPI source number. Opening the priority window with nothing pending, or ending an interrupt with nothing pending, sends a resend request to the source controller.

All notices (offer refusal, displaced-source reject, end-of-interrupt, resend) and the read data are driven in the same cycle as the request. The register state and the interrupt line update at the next rising clock edge.

Top module: `icp_core`

## Requirements
- R1: After reset the pending word is 0, the IPI priority reads 0xFF and the interrupt line is low. The pending priority is 0xFF, so an accept right after reset returns 0 and leaves a processor priority of 0xFF.
- R2: The pending word holds the processor priority in bits 31:24 and the source number in bits 23:0. Source 0 means nothing is pending, and the interrupt line is high exactly when the source field is non-zero.
- R3: An offer with priority P is refused (offer_reject high in the same cycle) when P is not below the processor priority, or when an interrupt is pending whose priority is at or below P. A refused offer changes no state.
- R4: An offer that is not refused loads its source number and priority, marks the source as owned by the source controller and raises the line. If an owned source was pending, rej_valid pulses with that source's number in the same cycle.
- R5: Accept (op code 1) returns the whole pending word on rd_data. After the edge the line is low, the processor priority equals the old pending priority, the source field is 0, and the pending priority is 0xFF.
- R6: Poll (op code 2) returns the pending word on rd_data and the IPI priority on rd_ipi, and changes no state.
- R7: Writing a processor priority (op code 3, value in bits 7:0) below the old one clears a pending interrupt when the new value is at or below the pending priority. The line drops and an owned source is rejected.
- R8: Writing a processor priority that is not below the old one, with nothing pending, pulses resend_req. If the IPI priority is below the new processor priority, the IPI check also runs.
- R9: Writing the IPI priority (op code 4, value in bits 7:0) below the processor priority runs the IPI check. The check does nothing if an interrupt is pending at a priority at or below the IPI priority. Otherwise it rejects any owned pending source, loads source number 2 at the IPI priority without an owner, and raises the line. Displacing a pending IPI gives no reject.
- R10: End-of-interrupt (op code 5) sets the processor priority from bits 31:24 of the written word and pulses eoi_valid with bits 23:0 on eoi_src. If nothing is pending, a resend follows as in R8. If something is pending, resend_req stays low.
- R11: An offer in the same cycle as any register operation is refused and has no effect on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number (non-zero) |
| offer_prio | input | 8 | Offered priority |
| offer_reject | output | 1 | Offer refused, same cycle |
| op_valid | input | 1 | Processor register operation this cycle |
| op_code | input | 3 | 1 accept, 2 poll, 3 processor priority, 4 IPI priority, 5 end-of-interrupt |
| op_wdata | input | 32 | Write data for op codes 3, 4, 5 |
| rd_data | output | 32 | Current pending word |
| rd_ipi | output | 8 | Current IPI priority |
| irq_out | output | 1 | Level interrupt to the processor |
| rej_valid | output | 1 | Displaced owned source is rejected |
| rej_src | output | 24 | Number of the rejected source |
| eoi_valid | output | 1 | End-of-interrupt notice |
| eoi_src | output | 24 | Source number carried by the notice |
| resend_req | output | 1 | Request to the source controller to re-offer |

## Verification
The assertions assume that offered source numbers are never 0 and never the IPI number 2. Under that assumption a reject notice always names a real owned source. They also assume that op codes outside 1 to 5 are simply idle. The bench offers only numbers such as 0x10 to 0x60, and it overlaps an offer with a register operation only in the scenario aimed at that rule. Because the judge only acts on the state after each edge, the stimulus changes inputs at falling edges and samples a settled cycle.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_POLL   = 3'd2,
    OP_CPPR   = 3'd3,
    OP_IPI    = 3'd4,
    OP_EOI    = 3'd5
  } op_e;
endpackage

// File: rtl/icp_offer_judge.sv
module icp_offer_judge #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] prio,
  input  logic [PW-1:0] cur_prio,
  input  logic          pending,
  input  logic [PW-1:0] pend_prio,
  output logic          lose
);
  function automatic logic offer_loses(input logic [PW-1:0] p, input logic [PW-1:0] c,
                                       input logic pd, input logic [PW-1:0] pp);
    return (p >= c) || (pd && (pp <= p));
  endfunction

  assign lose = offer_loses(prio, cur_prio, pending, pend_prio);
endmodule

// File: rtl/icp_ipi_judge.sv
module icp_ipi_judge #(
  parameter int PW = 8
) (
  input  logic          pending,
  input  logic [PW-1:0] pend_prio,
  input  logic [PW-1:0] ipi_prio,
  output logic          fire
);
  function automatic logic ipi_takes(input logic pd, input logic [PW-1:0] pp,
                                     input logic [PW-1:0] ip);
    return !(pd && (pp <= ip));
  endfunction

  assign fire = ipi_takes(pending, pend_prio, ipi_prio);
endmodule

// File: rtl/icp_core.sv
module icp_core
  import icp_pkg::*;
#(
  parameter int PW      = 8,
  parameter int SW      = 24,
  parameter int IPI_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             offer_valid,
  input  logic [SW-1:0]    offer_src,
  input  logic [PW-1:0]    offer_prio,
  output logic             offer_reject,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [PW+SW-1:0] op_wdata,
  output logic [PW+SW-1:0] rd_data,
  output logic [PW-1:0]    rd_ipi,
  output logic             irq_out,
  output logic             rej_valid,
  output logic [SW-1:0]    rej_src,
  output logic             eoi_valid,
  output logic [SW-1:0]    eoi_src,
  output logic             resend_req
);
  localparam int DW = PW + SW;
  localparam logic [PW-1:0] LEAST = {PW{1'b1}};
  localparam logic [SW-1:0] IPI_NUM = SW'(IPI_SRC);

  logic [PW-1:0] cppr_q, pend_q, mfrr_q;
  logic [SW-1:0] xisr_q;
  logic          owned_q, irq_q;
  logic [PW-1:0] cppr_d, pend_d, mfrr_d;
  logic [SW-1:0] xisr_d;
  logic          owned_d, irq_d;

  op_e           op;
  logic          pending;
  logic [PW-1:0] wr_lo, wr_hi, cppr_eff, mfrr_eff;
  logic          offer_lose, ipi_fire, run_ipi;
  logic          win_evt, clear_evt, ipi_evt;

  assign op       = op_e'(op_code);
  assign pending  = (xisr_q != '0);
  assign wr_lo    = op_wdata[PW-1:0];
  assign wr_hi    = op_wdata[DW-1:SW];
  assign cppr_eff = (op_valid && (op == OP_CPPR || op == OP_EOI)) ? ((op == OP_EOI) ? wr_hi : wr_lo) : cppr_q;
  assign mfrr_eff = (op_valid && op == OP_IPI) ? wr_lo : mfrr_q;

  icp_offer_judge #(.PW(PW)) u_offer (
    .prio(offer_prio), .cur_prio(cppr_q), .pending(pending),
    .pend_prio(pend_q), .lose(offer_lose)
  );

  icp_ipi_judge #(.PW(PW)) u_ipi (
    .pending(pending), .pend_prio(pend_q), .ipi_prio(mfrr_eff), .fire(ipi_fire)
  );

  always_comb begin
    cppr_d = cppr_q; pend_d = pend_q; mfrr_d = mfrr_q;
    xisr_d = xisr_q; owned_d = owned_q; irq_d = irq_q;
    offer_reject = 1'b0;
    rej_valid = 1'b0; rej_src = '0;
    eoi_valid = 1'b0; eoi_src = '0;
    resend_req = 1'b0;
    run_ipi = 1'b0;
    win_evt = 1'b0; clear_evt = 1'b0;
    if (op_valid) begin
      offer_reject = offer_valid;
      case (op)
        OP_ACCEPT: begin
          cppr_d = pend_q; xisr_d = '0; pend_d = LEAST; owned_d = 1'b0; irq_d = 1'b0;
        end
        OP_CPPR: begin
          cppr_d = wr_lo;
          if (wr_lo < cppr_q) begin
            if (pending && (wr_lo <= pend_q)) begin
              clear_evt = 1'b1;
              xisr_d = '0; pend_d = LEAST; irq_d = 1'b0; owned_d = 1'b0;
              if (owned_q) begin
                rej_valid = 1'b1; rej_src = xisr_q;
              end
            end
          end else if (!pending) begin
            resend_req = 1'b1;
            run_ipi = (mfrr_eff < cppr_eff);
          end
        end
        OP_IPI: begin
          mfrr_d = wr_lo;
          run_ipi = (mfrr_eff < cppr_eff);
        end
        OP_EOI: begin
          cppr_d = wr_hi;
          eoi_valid = 1'b1; eoi_src = op_wdata[SW-1:0];
          if (!pending) begin
            resend_req = 1'b1;
            run_ipi = (mfrr_eff < cppr_eff);
          end
        end
        default: ;
      endcase
    end else if (offer_valid) begin
      if (offer_lose) begin
        offer_reject = 1'b1;
      end else begin
        win_evt = 1'b1;
        if (pending && owned_q) begin
          rej_valid = 1'b1; rej_src = xisr_q;
        end
        xisr_d = offer_src; pend_d = offer_prio; owned_d = 1'b1; irq_d = 1'b1;
      end
    end
    ipi_evt = run_ipi && ipi_fire;
    if (ipi_evt) begin
      if (pending && owned_q) begin
        rej_valid = 1'b1; rej_src = xisr_q;
      end
      xisr_d = IPI_NUM; pend_d = mfrr_eff; owned_d = 1'b0; irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= '0; xisr_q <= '0; pend_q <= LEAST; mfrr_q <= LEAST;
      owned_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      cppr_q <= cppr_d; xisr_q <= xisr_d; pend_q <= pend_d; mfrr_q <= mfrr_d;
      owned_q <= owned_d; irq_q <= irq_d;
    end
  end

  assign rd_data = {cppr_q, xisr_q};
  assign rd_ipi  = mfrr_q;
  assign irq_out = irq_q;

  assert_line_tracks_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (xisr_q != '0));

  assert_offer_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |=> irq_q && (xisr_q == $past(offer_src)) && (pend_q == $past(offer_prio)));

  assert_accept_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_ACCEPT) |=> !irq_q && (xisr_q == '0) && (pend_q == LEAST));

  assert_poll_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_POLL) |=> $stable(xisr_q) && $stable(cppr_q) && $stable(mfrr_q) && $stable(irq_q));

  assert_clear_drops_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !irq_q);

  assert_ipi_never_rejected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != IPI_NUM) && (rej_src != '0));

  assert_ipi_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_evt |=> irq_q && (xisr_q == IPI_NUM));

  assert_eoi_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> cppr_q == $past(op_wdata[DW-1:SW]));

  assert_busy_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && op_valid) |=> $stable(pend_q) || !$stable(cppr_q) || $past(op == OP_IPI) || $past(op == OP_ACCEPT) || $past(op == OP_EOI));
endmodule

// File: tb/tb_icp_core.sv
`timescale 1ns/1ps
module tb_icp_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        offer_reject;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_wdata = '0;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi;
  logic        irq_out, rej_valid, eoi_valid, resend_req;
  logic [23:0] rej_src, eoi_src;

  int checks = 0;
  int errors = 0;

  logic [31:0] c_rd;
  logic [7:0]  c_ipi;
  logic        c_irq, c_offrej, c_rejv, c_eoiv, c_resend;
  logic [23:0] c_rejs, c_eois;

  always #2.5 clk = ~clk;

  icp_core dut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_reject(offer_reject),
    .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
    .rd_data(rd_data), .rd_ipi(rd_ipi), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ov, input logic [23:0] os, input logic [7:0] opr,
                      input logic pv, input logic [2:0] code, input logic [31:0] wd);
    @(negedge clk);
    offer_valid = ov; offer_src = os; offer_prio = opr;
    op_valid = pv; op_code = code; op_wdata = wd;
    #1;
    c_rd = rd_data; c_ipi = rd_ipi; c_irq = irq_out; c_offrej = offer_reject;
    c_rejv = rej_valid; c_rejs = rej_src; c_eoiv = eoi_valid; c_eois = eoi_src;
    c_resend = resend_req;
    @(posedge clk);
    #1;
    offer_valid = 1'b0; op_valid = 1'b0; op_code = '0; op_wdata = '0;
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    step(1'b1, s, p, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic op(input logic [2:0] code, input logic [31:0] wd);
    step(1'b0, 24'h0, 8'h0, 1'b1, code, wd);
  endtask

  task automatic poll_expect(input string tag, input logic [31:0] word, input logic line);
    op(3'd2, 32'h0);
    chk({tag, " word"}, c_rd, word);
    chk({tag, " line"}, {31'h0, c_irq}, {31'h0, line});
  endtask

  task automatic t_reset;
    poll_expect("R1 reset", 32'h0, 1'b0);
    chk("R1 ipi prio", {24'h0, c_ipi}, 32'hFF);
    op(3'd1, 32'h0);
    chk("R1 accept at reset", c_rd, 32'h0);
    poll_expect("R1 pend prio to cppr", 32'hFF00_0000, 1'b0);
  endtask

  task automatic t_offers;
    offer(24'h10, 8'h05);
    chk("R4 first win", {c_offrej, c_rejv}, 2'b00);
    poll_expect("R4 load", 32'hFF00_0010, 1'b1);
    poll_expect("R6 repeat poll", 32'hFF00_0010, 1'b1);
    offer(24'h20, 8'h05);
    chk("R3 equal pend", {31'h0, c_offrej}, 1);
    offer(24'h20, 8'h03);
    chk("R4 displace", {c_offrej, c_rejv}, 2'b01);
    chk("R4 displaced src", {8'h0, c_rejs}, 32'h10);
    poll_expect("R4 new load", 32'hFF00_0020, 1'b1);
    offer(24'h25, 8'hFF);
    chk("R3 not below cppr", {31'h0, c_offrej}, 1);
    poll_expect("R3 no effect", 32'hFF00_0020, 1'b1);
  endtask

  task automatic t_accept_cppr;
    op(3'd1, 32'h0);
    chk("R5 accept word", c_rd, 32'hFF00_0020);
    poll_expect("R5 after accept", 32'h0300_0000, 1'b0);
    offer(24'h30, 8'h03);
    chk("R3 equal cppr", {31'h0, c_offrej}, 1);
    offer(24'h30, 8'h02);
    chk("R4 win", {31'h0, c_offrej}, 0);
    op(3'd3, 32'h01);
    chk("R7 reject owner", {c_rejv, c_resend}, 2'b10);
    chk("R7 reject src", {8'h0, c_rejs}, 32'h30);
    poll_expect("R7 cleared", 32'h0100_0000, 1'b0);
    op(3'd3, 32'h04);
    chk("R8 resend", {c_resend, c_rejv}, 2'b10);
    poll_expect("R8 no ipi", 32'h0400_0000, 1'b0);
  endtask

  task automatic t_ipi;
    op(3'd4, 32'h06);
    poll_expect("R9 ipi not below", 32'h0400_0000, 1'b0);
    chk("R9 ipi stored", {24'h0, c_ipi}, 32'h06);
    op(3'd4, 32'h03);
    chk("R9 no reject when empty", {31'h0, c_rejv}, 0);
    poll_expect("R9 ipi loaded", 32'h0400_0002, 1'b1);
    offer(24'h40, 8'h01);
    chk("R9 ipi displaced no reject", {c_offrej, c_rejv}, 2'b00);
    poll_expect("R9 offer over ipi", 32'h0400_0040, 1'b1);
    op(3'd4, 32'h02);
    poll_expect("R9 check idle", 32'h0400_0040, 1'b1);
    op(3'd4, 32'h00);
    chk("R9 owned rejected", {31'h0, c_rejv}, 1);
    chk("R9 rejected src", {8'h0, c_rejs}, 32'h40);
    poll_expect("R9 ipi preempts", 32'h0400_0002, 1'b1);
  endtask

  task automatic t_eoi;
    op(3'd1, 32'h0);
    chk("R5 accept ipi", c_rd, 32'h0400_0002);
    poll_expect("R5 cppr zero", 32'h0000_0000, 1'b0);
    op(3'd5, 32'h0500_0040);
    chk("R10 eoi notice", {c_eoiv, c_resend, c_rejv}, 3'b110);
    chk("R10 eoi src", {8'h0, c_eois}, 32'h40);
    poll_expect("R8 resend runs ipi", 32'h0500_0002, 1'b1);
    op(3'd1, 32'h0);
    op(3'd4, 32'hFF);
    op(3'd5, 32'h0A00_0002);
    chk("R10 resend empty", {31'h0, c_resend}, 1);
    poll_expect("R10 cppr restored", 32'h0A00_0000, 1'b0);
    offer(24'h60, 8'h02);
    op(3'd5, 32'h0A00_0010);
    chk("R10 no resend when pending", {c_eoiv, c_resend}, 2'b10);
    chk("R10 eoi src2", {8'h0, c_eois}, 32'h10);
    poll_expect("R10 pending kept", 32'h0A00_0060, 1'b1);
  endtask

  task automatic t_busy;
    op(3'd1, 32'h0);
    step(1'b1, 24'h50, 8'h01, 1'b1, 3'd2, 32'h0);
    chk("R11 busy reject", {31'h0, c_offrej}, 1);
    poll_expect("R11 no effect", 32'h0200_0000, 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offers();
    t_accept_cppr();
    t_ipi();
    t_eoi();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule